// File: doc/BRIEF.md
# Two-Bank SDRAM Command Legality Tracker

This block sits beside the command bus of a two-bank synchronous DRAM and watches it on every rising clock edge. From the row strobe, column strobe and write enable levels it decodes the command. The command is one of bank activate, read, write, precharge, burst stop or no operation. The block then updates what it knows about the addressed bank: whether it is idle or active, which row it holds open, and how many cycles have passed since that bank was activated.

Each read, write or activate is judged against those per-bank records in the same cycle it is seen. The following commands are flagged, with a code that names the broken rule:
- an access to an idle bank,
- an access to a row other than the one held open,
- an access issued before the configured activate-to-access delay has run out,
- an activate sent to a bank that is already open.

Commands may arrive on every clock and may alternate freely between the two banks. Each bank keeps its own records, so the two banks never interfere. The block only observes: it drives nothing back onto the bus. It is meant as a protocol monitor inside a memory controller or a verification harness.

The decoded command strobes, the error flag, the error code and the faulting bank all appear one clock after the command edge. The bank state and the open row change on the command edge itself.

Top module: `sdram_bank_guard`

## Requirements
- R1: Read is decoded when (ras_n, cas_n, we_n) = (1,0,1) and write when (1,0,0); the matching strobe `stb_rd` or `stb_wr` is high for the one cycle after that edge, and at most one strobe is ever high.
- R2: Activate is decoded at (0,1,1), precharge at (0,1,0) and burst stop at (1,1,0), each raising `stb_act`, `stb_pre` or `stb_bst` for one cycle; (1,1,1) is no operation and raises no strobe; burst stop changes no bank state.
- R3: An activate to an idle bank makes that bank active after the edge, with `open_row` slice `[b*ROW_W +: ROW_W]` holding the row given with the command.
- R4: A precharge makes the addressed bank idle after the edge and clears its `open_row` slice to zero; a precharge to an idle bank is legal.
- R5: A read or write to an active bank whose row matches the open row, once the delay has elapsed, gives error code 0 and does not change the bank state; repeated accesses need no precharge.
- R6: Each bank's elapsed count becomes 1 on the activate edge and rises by one per later edge, saturating at 7; an access is legal only when the count at its edge is at least `trcd_cfg` (1 to 7), otherwise code 1 (too early).
- R7: A read or write to an idle bank gives code 2.
- R8: A read or write to an active bank with a different row gives code 3; code 2 takes priority over code 3, and code 3 over code 1.
- R9: An activate to an already active bank gives code 4 and leaves that bank's state and open row unchanged.
- R10: The two banks are tracked independently: a command to one bank never changes the other bank's state, and accesses may alternate between banks on consecutive clocks.
- R11: During reset both banks are idle, both open rows are zero, all strobes are low, `err_flag` is low and `err_code` is 0.
- R12: `err_flag` is high exactly in the cycle after an illegal command, with `err_code` nonzero and `err_bank` naming the command's bank; it falls when the next command is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_ras_n | input | 1 | Row strobe level of the observed bus |
| cmd_cas_n | input | 1 | Column strobe level of the observed bus |
| cmd_we_n | input | 1 | Write enable level of the observed bus |
| cmd_bank | input | BANK_W | Bank select of the command |
| cmd_row | input | ROW_W | Row opened by an activate, or row targeted by an access |
| trcd_cfg | input | CNT_W | Activate-to-access delay in cycles, 1 to 7 |
| stb_act | output | 1 | Activate seen on the previous edge |
| stb_rd | output | 1 | Read seen on the previous edge |
| stb_wr | output | 1 | Write seen on the previous edge |
| stb_pre | output | 1 | Precharge seen on the previous edge |
| stb_bst | output | 1 | Burst stop seen on the previous edge |
| bank_active | output | BANKS | Per-bank active flag, bit b for bank b |
| open_row | output | BANKS*ROW_W | Open row per bank, bank b at [b*ROW_W +: ROW_W] |
| err_flag | output | 1 | Previous command was illegal |
| err_code | output | 3 | 0 none, 1 too early, 2 idle bank, 3 wrong row, 4 bank already open |
| err_bank | output | BANK_W | Bank of the illegal command |

## Verification
Two things happen on the same edge: the legality check of an access reads a bank's elapsed count, and that count advances or restarts. The sharpest cases are an access exactly at the delay threshold and an access one cycle after its bank's activate. The table walk provokes this by interleaving an activate to one bank with accesses to the other. It then reaches the threshold on the first bank with the second bank's count still running. Each case is judged from the error code one cycle later, together with both banks' active flags, which must show that the other bank was not disturbed.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

   typedef enum logic [2:0] {
      CMD_NOP   = 3'd0,
      CMD_ACT   = 3'd1,
      CMD_RD    = 3'd2,
      CMD_WR    = 3'd3,
      CMD_PRE   = 3'd4,
      CMD_BST   = 3'd5,
      CMD_OTHER = 3'd6
   } cmd_e;

   typedef enum logic [2:0] {
      ERR_NONE  = 3'd0,
      ERR_EARLY = 3'd1,
      ERR_IDLE  = 3'd2,
      ERR_ROW   = 3'd3,
      ERR_BUSY  = 3'd4
   } err_e;

   // Map pin levels {ras_n, cas_n, we_n} to a command
   function automatic cmd_e pins_to_cmd(input logic ras_n, input logic cas_n,
                                        input logic we_n);
      cmd_e c;
      case ({ras_n, cas_n, we_n})
         3'b111:  c = CMD_NOP;
         3'b011:  c = CMD_ACT;
         3'b101:  c = CMD_RD;
         3'b100:  c = CMD_WR;
         3'b010:  c = CMD_PRE;
         3'b110:  c = CMD_BST;
         default: c = CMD_OTHER;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/sbg_cmd_decode.sv
module sbg_cmd_decode
   import sbg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd,
   output logic stb_act,
   output logic stb_rd,
   output logic stb_wr,
   output logic stb_pre,
   output logic stb_bst
);

   always_comb cmd = pins_to_cmd(ras_n, cas_n, we_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb_act <= 1'b0;
         stb_rd  <= 1'b0;
         stb_wr  <= 1'b0;
         stb_pre <= 1'b0;
         stb_bst <= 1'b0;
      end else begin
         stb_act <= (cmd == CMD_ACT);
         stb_rd  <= (cmd == CMD_RD);
         stb_wr  <= (cmd == CMD_WR);
         stb_pre <= (cmd == CMD_PRE);
         stb_bst <= (cmd == CMD_BST);
      end
   end

endmodule

// File: rtl/sbg_bank_track.sv
module sbg_bank_track #(
   parameter int ROW_W = 11,
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_go,
   input  logic             pre_go,
   input  logic [ROW_W-1:0] act_row,
   output logic             active,
   output logic [ROW_W-1:0] row_q,
   output logic [CNT_W-1:0] elapsed
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         row_q   <= '0;
         elapsed <= '0;
      end else if (act_go) begin
         active  <= 1'b1;
         row_q   <= act_row;
         elapsed <= CNT_ONE;
      end else if (pre_go) begin
         active  <= 1'b0;
         row_q   <= '0;
         elapsed <= '0;
      end else if (active && (elapsed != CNT_MAX)) begin
         elapsed <= elapsed + CNT_ONE;
      end
   end

endmodule

// File: rtl/sbg_rule_check.sv
module sbg_rule_check
   import sbg_pkg::*;
#(
   parameter int BANKS = 2,
   parameter int ROW_W = 11,
   parameter int CNT_W = 3,
   localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
   input  cmd_e                   cmd,
   input  logic [BANK_W-1:0]      bank,
   input  logic [ROW_W-1:0]       row,
   input  logic [CNT_W-1:0]       trcd,
   input  logic [BANKS-1:0]       active,
   input  logic [BANKS*ROW_W-1:0] rows_flat,
   input  logic [BANKS*CNT_W-1:0] elapsed_flat,
   output err_e                   code
);

   logic             sel_active;
   logic [ROW_W-1:0] sel_row;
   logic [CNT_W-1:0] sel_elapsed;

   always_comb begin
      sel_active  = active[bank];
      sel_row     = rows_flat[bank*ROW_W +: ROW_W];
      sel_elapsed = elapsed_flat[bank*CNT_W +: CNT_W];
   end

   always_comb begin
      code = ERR_NONE;
      case (cmd)
         CMD_RD, CMD_WR: begin
            if (!sel_active)              code = ERR_IDLE;
            else if (sel_row != row)      code = ERR_ROW;
            else if (sel_elapsed < trcd)  code = ERR_EARLY;
         end
         CMD_ACT: begin
            if (sel_active)               code = ERR_BUSY;
         end
         default: code = ERR_NONE;
      endcase
   end

endmodule

// File: rtl/sdram_bank_guard.sv
module sdram_bank_guard
   import sbg_pkg::*;
#(
   parameter int BANKS = 2,
   parameter int ROW_W = 11,
   parameter int CNT_W = 3,
   localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_ras_n,
   input  logic                   cmd_cas_n,
   input  logic                   cmd_we_n,
   input  logic [BANK_W-1:0]      cmd_bank,
   input  logic [ROW_W-1:0]       cmd_row,
   input  logic [CNT_W-1:0]       trcd_cfg,
   output logic                   stb_act,
   output logic                   stb_rd,
   output logic                   stb_wr,
   output logic                   stb_pre,
   output logic                   stb_bst,
   output logic [BANKS-1:0]       bank_active,
   output logic [BANKS*ROW_W-1:0] open_row,
   output logic                   err_flag,
   output logic [2:0]             err_code,
   output logic [BANK_W-1:0]      err_bank
);

   // Elaboration-time parameter checks
   if (BANKS < 2 || (BANKS & (BANKS - 1)) != 0) begin : g_bad_banks
      $error("BANKS must be a power of two, at least 2");
   end
   if (ROW_W < 1) begin : g_bad_row
      $error("ROW_W must be at least 1");
   end
   if (CNT_W < 3) begin : g_bad_cnt
      $error("CNT_W must hold a delay of 7");
   end

   cmd_e                   cmd;
   err_e                   code;
   logic [BANKS*CNT_W-1:0] elapsed_flat;

   sbg_cmd_decode u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .ras_n   (cmd_ras_n),
      .cas_n   (cmd_cas_n),
      .we_n    (cmd_we_n),
      .cmd     (cmd),
      .stb_act (stb_act),
      .stb_rd  (stb_rd),
      .stb_wr  (stb_wr),
      .stb_pre (stb_pre),
      .stb_bst (stb_bst)
   );

   for (genvar gi = 0; gi < BANKS; gi++) begin : g_bank
      logic hit, act_go, pre_go;
      always_comb begin
         hit    = (cmd_bank == BANK_W'(gi));
         act_go = hit && (cmd == CMD_ACT) && !bank_active[gi];
         pre_go = hit && (cmd == CMD_PRE);
      end
      sbg_bank_track #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_trk (
         .clk     (clk),
         .rst_n   (rst_n),
         .act_go  (act_go),
         .pre_go  (pre_go),
         .act_row (cmd_row),
         .active  (bank_active[gi]),
         .row_q   (open_row[gi*ROW_W +: ROW_W]),
         .elapsed (elapsed_flat[gi*CNT_W +: CNT_W])
      );
   end

   sbg_rule_check #(.BANKS(BANKS), .ROW_W(ROW_W), .CNT_W(CNT_W)) u_rule (
      .cmd          (cmd),
      .bank         (cmd_bank),
      .row          (cmd_row),
      .trcd         (trcd_cfg),
      .active       (bank_active),
      .rows_flat    (open_row),
      .elapsed_flat (elapsed_flat),
      .code         (code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_flag <= 1'b0;
         err_code <= 3'd0;
         err_bank <= '0;
      end else begin
         err_flag <= (code != ERR_NONE);
         err_code <= code;
         err_bank <= (code != ERR_NONE) ? cmd_bank : '0;
      end
   end

endmodule

// File: rtl/sbg_checker.sv
module sbg_checker #(
   parameter int BANKS = 2,
   parameter int ROW_W = 11,
   localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cmd_ras_n,
   input logic                   cmd_cas_n,
   input logic                   cmd_we_n,
   input logic [BANK_W-1:0]      cmd_bank,
   input logic [ROW_W-1:0]       cmd_row,
   input logic                   stb_act,
   input logic                   stb_rd,
   input logic                   stb_wr,
   input logic                   stb_pre,
   input logic                   stb_bst,
   input logic [BANKS-1:0]       bank_active,
   input logic [BANKS*ROW_W-1:0] open_row,
   input logic                   err_flag,
   input logic [2:0]             err_code
);

   logic pin_act, pin_pre, pin_acc;
   always_comb begin
      pin_act = !cmd_ras_n &&  cmd_cas_n &&  cmd_we_n;
      pin_pre = !cmd_ras_n &&  cmd_cas_n && !cmd_we_n;
      pin_acc =  cmd_ras_n && !cmd_cas_n;
   end

   a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({stb_act, stb_rd, stb_wr, stb_pre, stb_bst}));

   a_r12_err_from_check: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |-> (stb_rd || stb_wr || stb_act) && (err_code != 3'd0));

   a_r7_idle_access: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_acc && !bank_active[cmd_bank]) |=> (err_flag && err_code == 3'd2));

   a_r4_pre_idles: assert property (@(posedge clk) disable iff (!rst_n)
      pin_pre |=> (!bank_active[$past(cmd_bank)] &&
                   open_row[$past(cmd_bank)*ROW_W +: ROW_W] == '0));

   a_r3_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_act && !bank_active[cmd_bank]) |=>
         (bank_active[$past(cmd_bank)] &&
          open_row[$past(cmd_bank)*ROW_W +: ROW_W] == $past(cmd_row) &&
          !err_flag));

   a_r9_act_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_act && bank_active[cmd_bank]) |=>
         (err_code == 3'd4 && $stable(open_row) && $stable(bank_active)));

   a_r10_bank1_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_bank != BANK_W'(1)) |=> $stable(bank_active[1]));

endmodule

bind sdram_bank_guard sbg_checker #(.BANKS(BANKS), .ROW_W(ROW_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_ras_n   (cmd_ras_n),
   .cmd_cas_n   (cmd_cas_n),
   .cmd_we_n    (cmd_we_n),
   .cmd_bank    (cmd_bank),
   .cmd_row     (cmd_row),
   .stb_act     (stb_act),
   .stb_rd      (stb_rd),
   .stb_wr      (stb_wr),
   .stb_pre     (stb_pre),
   .stb_bst     (stb_bst),
   .bank_active (bank_active),
   .open_row    (open_row),
   .err_flag    (err_flag),
   .err_code    (err_code)
);

// File: tb/sdram_bank_guard_tb.sv
module sdram_bank_guard_tb_top;

   localparam int ROW_W = 11;
   localparam int CNT_W = 3;

   // Pin levels {ras_n, cas_n, we_n}
   localparam logic [2:0] C_NOP = 3'b111;
   localparam logic [2:0] C_ACT = 3'b011;
   localparam logic [2:0] C_RD  = 3'b101;
   localparam logic [2:0] C_WR  = 3'b100;
   localparam logic [2:0] C_PRE = 3'b010;
   localparam logic [2:0] C_BST = 3'b110;

   typedef struct packed {
      logic [2:0]       cmd;
      logic             bank;
      logic [ROW_W-1:0] row;
      logic [2:0]       code;
      logic [1:0]       act;   // expected bank_active after the edge
      logic [3:0]       req;
   } vec_t;

   localparam int NV = 19;
   // tRCD = 3 throughout the table
   localparam vec_t VEC [NV] = '{
      '{C_RD,  1'b0, 11'd5, 3'd2, 2'b00, 4'd7},   // R7 idle bank
      '{C_ACT, 1'b0, 11'd5, 3'd0, 2'b01, 4'd3},   // R3 open bank 0
      '{C_RD,  1'b0, 11'd5, 3'd1, 2'b01, 4'd6},   // R6 count 1 < 3
      '{C_ACT, 1'b1, 11'd9, 3'd0, 2'b11, 4'd10},  // R10 open bank 1
      '{C_RD,  1'b0, 11'd5, 3'd0, 2'b11, 4'd6},   // R6 count 3 == 3
      '{C_WR,  1'b1, 11'd9, 3'd1, 2'b11, 4'd6},   // R6 bank 1 count 2
      '{C_WR,  1'b1, 11'd9, 3'd0, 2'b11, 4'd5},   // R5
      '{C_RD,  1'b0, 11'd5, 3'd0, 2'b11, 4'd10},  // R10 alternate
      '{C_WR,  1'b0, 11'd7, 3'd3, 2'b11, 4'd8},   // R8 wrong row
      '{C_ACT, 1'b0, 11'd7, 3'd4, 2'b11, 4'd9},   // R9 busy
      '{C_PRE, 1'b0, 11'd0, 3'd0, 2'b10, 4'd4},   // R4
      '{C_RD,  1'b0, 11'd7, 3'd2, 2'b10, 4'd8},   // R8 idle before row
      '{C_ACT, 1'b0, 11'd7, 3'd0, 2'b11, 4'd3},   // R3
      '{C_RD,  1'b0, 11'd1, 3'd3, 2'b11, 4'd8},   // R8 row before early
      '{C_BST, 1'b1, 11'd0, 3'd0, 2'b11, 4'd2},   // R2 burst stop
      '{C_NOP, 1'b0, 11'd0, 3'd0, 2'b11, 4'd2},   // R2 no operation
      '{C_RD,  1'b1, 11'd9, 3'd0, 2'b11, 4'd5},   // R5 repeat access
      '{C_PRE, 1'b1, 11'd0, 3'd0, 2'b01, 4'd4},   // R4
      '{C_PRE, 1'b1, 11'd0, 3'd0, 2'b01, 4'd4}    // R4 idle precharge
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic             bank = 1'b0;
   logic [ROW_W-1:0] row = '0;
   logic [CNT_W-1:0] trcd = 3'd3;
   logic             stb_act, stb_rd, stb_wr, stb_pre, stb_bst;
   logic [1:0]       bank_active;
   logic [2*ROW_W-1:0] open_row;
   logic             err_flag;
   logic [2:0]       err_code;
   logic             err_bank;

   int n_checks = 0;
   int n_errors = 0;

   always #5 clk = ~clk;

   sdram_bank_guard #(.BANKS(2), .ROW_W(ROW_W), .CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n),
      .cmd_bank(bank), .cmd_row(row), .trcd_cfg(trcd),
      .stb_act(stb_act), .stb_rd(stb_rd), .stb_wr(stb_wr),
      .stb_pre(stb_pre), .stb_bst(stb_bst),
      .bank_active(bank_active), .open_row(open_row),
      .err_flag(err_flag), .err_code(err_code), .err_bank(err_bank)
   );

   task automatic chk(input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [4:0] exp_stb(input logic [2:0] c);
      case (c)
         C_ACT:   return 5'b10000;
         C_RD:    return 5'b01000;
         C_WR:    return 5'b00100;
         C_PRE:   return 5'b00010;
         C_BST:   return 5'b00001;
         default: return 5'b00000;
      endcase
   endfunction

   // Drive a command, then wait to the next falling edge
   task automatic issue(input logic [2:0] c, input logic b,
                        input logic [ROW_W-1:0] r);
      {ras_n, cas_n, we_n} = c;
      bank = b;
      row  = r;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 active", 32'(bank_active), 32'd0);
      chk("R11 rows", 32'(open_row), 32'd0);
      chk("R11 err", 32'({err_flag, err_code}), 32'd0);
      chk("R11 strobes", 32'({stb_act, stb_rd, stb_wr, stb_pre, stb_bst}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         issue(VEC[i].cmd, VEC[i].bank, VEC[i].row);
         chk($sformatf("R%0d vec%0d code", VEC[i].req, i), 32'(err_code), 32'(VEC[i].code));
         chk($sformatf("R12 vec%0d flag", i), 32'(err_flag), 32'(VEC[i].code != 3'd0));
         chk($sformatf("R10 vec%0d active", i), 32'(bank_active), 32'(VEC[i].act));
         chk($sformatf("R1 vec%0d strobe", i),
             32'({stb_act, stb_rd, stb_wr, stb_pre, stb_bst}), 32'(exp_stb(VEC[i].cmd)));
      end

      // R3 / R4 open rows after the table: bank 0 row 7, bank 1 cleared
      chk("R3 bank0 row", 32'(open_row[0 +: ROW_W]), 32'd7);
      chk("R4 bank1 row", 32'(open_row[ROW_W +: ROW_W]), 32'd0);

      // R6 boundary: delay 1 allows the access on the next clock
      trcd = 3'd1;
      issue(C_ACT, 1'b1, 11'd3);
      issue(C_RD, 1'b1, 11'd3);
      chk("R6 trcd1 next-cycle read", 32'(err_code), 32'd0);

      // R6 saturation with delay 7
      trcd = 3'd7;
      issue(C_PRE, 1'b1, 11'd0);
      issue(C_ACT, 1'b1, 11'd3);
      repeat (5) issue(C_NOP, 1'b0, 11'd0);
      issue(C_WR, 1'b1, 11'd3);
      chk("R6 count 6 < 7", 32'(err_code), 32'd1);
      chk("R12 err_bank", 32'(err_bank), 32'd1);
      issue(C_WR, 1'b1, 11'd3);
      chk("R6 count 7 ok", 32'(err_code), 32'd0);
      chk("R12 flag falls", 32'(err_flag), 32'd0);
      repeat (12) issue(C_NOP, 1'b0, 11'd0);
      issue(C_RD, 1'b1, 11'd3);
      chk("R6 saturated, no wrap", 32'(err_code), 32'd0);

      // R9 busy activate keeps old row
      issue(C_ACT, 1'b1, 11'd44);
      chk("R9 code", 32'(err_code), 32'd4);
      chk("R9 row kept", 32'(open_row[ROW_W +: ROW_W]), 32'd3);

      // R11 reset in mid operation
      rst_n = 1'b0;
      @(negedge clk);
      chk("R11 mid reset active", 32'(bank_active), 32'd0);
      chk("R11 mid reset rows", 32'(open_row), 32'd0);
      chk("R11 mid reset err", 32'(err_flag), 32'd0);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule